// File: doc/BRIEF.md
# Banked Register File with Indirect Access

This block is the data-memory front end of a small microcontroller core. The core presents a 7-bit direct file offset. The block extends that offset with two bank-select bits, taken from a status register that it holds itself, to form a 9-bit data address. It then resolves the address to one physical byte or to a hole. Every bank starts with a small special-function area and continues with general-purpose bytes. Some special-function offsets refer to one shared register in every bank. Part of bank 1's general-purpose range falls through to bank 0. Unimplemented locations read as zero and ignore writes.

Offset 00h is a virtual indirection register and has no storage. An access to it uses the address held in the pointer register at offset 04h. The 8-bit pointer gives the low eight address bits, and status bit 7 gives the ninth. Reads are combinational, from address to data.

Writes enter through a valid/ready port. `wr_ready` is always high, so the block never applies back-pressure: every cycle with `wr_valid` high commits one write on the next rising clock edge. The block exposes the current bank and the pointer value so that neighbouring logic can follow them.

Top module: `rfb_top`

## Requirements
- R1: The bank comes from status bits 6:5 (00 is bank 0 through 11 is bank 3), and the address is {bank, offset}. A status write is used from the access after its clock edge. A read in the same cycle still sees the old bank.
- R2: `rd_data` follows `rd_addr` combinationally. A write commits on the rising edge only when `wr_valid` and `wr_ready` are both high. `wr_ready` is always 1, and `wr_valid` low changes nothing.
- R3: Offsets 02h, 03h (status), 04h (pointer), 0Ah and 0Bh are each one physical register, reached from every bank.
- R4: The other special-function offsets (01h, 05h–09h) hold separate bytes in bank 0 and in bank 1. In banks 2 and 3 they are holes.
- R5: Bank 0 offsets 0Ch–7Fh are general-purpose bytes that read back what was written.
- R6: Bank 1 offsets 0Ch up to ALIAS_END-1 reach the bank-0 byte at the same offset.
- R7: Bank 1 offsets ALIAS_END up to B1_OWN_END-1 are bank-1 storage, separate from bank 0. Bank 1 offsets from B1_OWN_END to 7Fh are holes.
- R8: Offsets 0Ch–7Fh in banks 2 and 3 are holes. A hole reads 00h and a write to it has no effect.
- R9: Offset 00h accesses the location {status[7], pointer[7:0]}. An indirect write stores to that location.
- R10: If the pointer addresses offset 00h of any bank (pointer[6:0] = 0), an indirect read returns 00h and an indirect write has no effect.
- R11: After reset every stored byte is 00h, so the bank is 0 and the pointer is 00h.
- R12: `bank_sel` always equals status[6:5] and `ptr_val` always equals the pointer register. Only writes that reach offset 04h change the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 7 | Direct offset for the read port |
| rd_data | output | 8 | Read data, combinational |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept, constant 1 |
| wr_addr | input | 7 | Direct offset for the write port |
| wr_data | input | 8 | Write data |
| bank_sel | output | 2 | Current bank (status bits 6:5) |
| ptr_val | output | 8 | Current pointer register |

## Verification
The bench builds the block with ALIAS_END = 48 and B1_OWN_END = 80. With these values bank 1 contains all three of its general-purpose regions: the alias window 8Ch–AFh, its own bytes at B0h–CFh, and a hole from D0h upward. The default build, which has no bank-1 storage, leaves out the middle region. These values let the bench check an indirect pointer into bank-1 storage, and also an alias write seen from bank 0.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int OFS_W  = 7;
  localparam int BANK_W = 2;
  localparam int DATA_W = 8;
  localparam int FULL_W = BANK_W + OFS_W;
  localparam int BANK_SPAN = 1 << OFS_W;

  localparam logic [OFS_W-1:0] OFS_IND    = 7'h00;
  localparam logic [OFS_W-1:0] OFS_STATUS = 7'h03;
  localparam logic [OFS_W-1:0] OFS_PTR    = 7'h04;

  // status register bit positions
  localparam int ST_IND_BANK = 7;
  localparam int ST_BANK_LO  = 5;

  typedef enum logic [2:0] {
    MK_HOLE,
    MK_SHARED,
    MK_SFR1,
    MK_GPR0,
    MK_GPR1
  } map_kind_e;
endpackage

// File: rtl/rfb_bank_map.sv
module rfb_bank_map
  import rfb_pkg::*;
#(
  parameter int SFR_END = 12,
  parameter int ALIAS_END = 48,
  parameter int B1_OWN_END = 48,
  parameter logic [15:0] MIRROR_MASK = 16'h0C1C,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  addr,
  input  logic [BANK_W-1:0] bank,
  input  logic              ind_bank,
  input  logic [7:0]        ptr,
  output logic              hole,
  output logic [IDX_W-1:0]  idx
);
  localparam int G0_BASE  = 2 * SFR_END;
  localparam int G0_DEPTH = BANK_SPAN - SFR_END;
  localparam int G1_BASE  = G0_BASE + G0_DEPTH;

  logic              is_ind;
  logic [FULL_W-1:0] full;
  logic [BANK_W-1:0] fb;
  logic [OFS_W-1:0]  fo;
  int                ofs;
  map_kind_e         kind;

  always_comb begin
    is_ind = (addr == OFS_IND);
    full   = is_ind ? {ind_bank, ptr} : {bank, addr};
    fb     = full[FULL_W-1:OFS_W];
    fo     = full[OFS_W-1:0];
    ofs    = int'(fo);
    kind   = MK_HOLE;
    if (fo == OFS_IND) begin
      kind = MK_HOLE;
    end else if (ofs < SFR_END) begin
      if (MIRROR_MASK[fo[3:0]] || fb == 2'd0) kind = MK_SHARED;
      else if (fb == 2'd1)                    kind = MK_SFR1;
    end else if (fb == 2'd0) begin
      kind = MK_GPR0;
    end else if (fb == 2'd1) begin
      if (ofs < ALIAS_END)       kind = MK_GPR0;
      else if (ofs < B1_OWN_END) kind = MK_GPR1;
    end
  end

  always_comb begin
    idx = '0;
    case (kind)
      MK_SHARED: idx = IDX_W'(ofs);
      MK_SFR1:   idx = IDX_W'(SFR_END + ofs);
      MK_GPR0:   idx = IDX_W'(G0_BASE + ofs - SFR_END);
      MK_GPR1:   idx = IDX_W'(G1_BASE + ofs - ALIAS_END);
      default:   idx = '0;
    endcase
  end

  assign hole = (kind == MK_HOLE);

  // R10
  ind_self_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ind && ptr[OFS_W-1:0] == OFS_IND) |-> hole);

  // R6
  alias_to_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_ind && bank == 2'd1 && int'(addr) >= SFR_END && int'(addr) < ALIAS_END)
      |-> (!hole && int'(idx) >= G0_BASE && int'(idx) < G1_BASE));
endmodule

// File: rtl/rfb_store.sv
module rfb_store
  import rfb_pkg::*;
#(
  parameter int DEPTH = 140,
  parameter int IDX_W = 8,
  parameter int STATUS_IDX = 3,
  parameter int PTR_IDX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] ptr_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata    = mem[ridx];
  assign status_q = mem[STATUS_IDX];
  assign ptr_q    = mem[PTR_IDX];

  // R1
  status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(widx) == STATUS_IDX) |=> status_q == $past(wdata));

  // R12
  ptr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && int'(widx) == PTR_IDX) |=> $stable(ptr_q));
endmodule

// File: rtl/rfb_top.sv
module rfb_top
  import rfb_pkg::*;
#(
  parameter int SFR_END = 12,
  parameter int ALIAS_END = 48,
  parameter int B1_OWN_END = 48,
  parameter logic [15:0] MIRROR_MASK = 16'h0C1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [OFS_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BANK_W-1:0] bank_sel,
  output logic [DATA_W-1:0] ptr_val
);
  localparam int G0_DEPTH = BANK_SPAN - SFR_END;
  localparam int G1_DEPTH = B1_OWN_END - ALIAS_END;
  localparam int DEPTH    = 2 * SFR_END + G0_DEPTH + G1_DEPTH;
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int STATUS_IDX = int'(OFS_STATUS);
  localparam int PTR_IDX    = int'(OFS_PTR);

  logic              rd_hole, wr_hole, wr_fire;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [DATA_W-1:0] store_rdata, status_q, ptr_q;

  rfb_bank_map #(
    .SFR_END(SFR_END), .ALIAS_END(ALIAS_END), .B1_OWN_END(B1_OWN_END),
    .MIRROR_MASK(MIRROR_MASK), .IDX_W(IDX_W)
  ) u_rmap (
    .clk(clk), .rst_n(rst_n), .addr(rd_addr),
    .bank(status_q[ST_BANK_LO +: BANK_W]), .ind_bank(status_q[ST_IND_BANK]),
    .ptr(ptr_q), .hole(rd_hole), .idx(rd_idx)
  );

  rfb_bank_map #(
    .SFR_END(SFR_END), .ALIAS_END(ALIAS_END), .B1_OWN_END(B1_OWN_END),
    .MIRROR_MASK(MIRROR_MASK), .IDX_W(IDX_W)
  ) u_wmap (
    .clk(clk), .rst_n(rst_n), .addr(wr_addr),
    .bank(status_q[ST_BANK_LO +: BANK_W]), .ind_bank(status_q[ST_IND_BANK]),
    .ptr(ptr_q), .hole(wr_hole), .idx(wr_idx)
  );

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready && !wr_hole;

  rfb_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .STATUS_IDX(STATUS_IDX), .PTR_IDX(PTR_IDX)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .widx(wr_idx), .wdata(wr_data),
    .ridx(rd_idx), .rdata(store_rdata), .status_q(status_q), .ptr_q(ptr_q)
  );

  assign rd_data  = rd_hole ? '0 : store_rdata;
  assign bank_sel = status_q[ST_BANK_LO +: BANK_W];
  assign ptr_val  = ptr_q;

  // R1
  bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_hole && int'(wr_idx) == STATUS_IDX)
      |=> bank_sel == $past(wr_data[ST_BANK_LO +: BANK_W]));

  // R8
  hole_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_hole) |=> ($stable(bank_sel) && $stable(ptr_val)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(bank_sel) && $stable(ptr_val)));
endmodule

// File: tb/rfb_top_bench.sv
module rfb_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] bank_sel;
  logic [7:0] ptr_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rfb_top #(.ALIAS_END(48), .B1_OWN_END(80)) u_rfb_top (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank_sel(bank_sel), .ptr_val(ptr_val)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic set_status(input logic [7:0] s);
    wr(7'h03, s);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 bank after reset", {6'd0, bank_sel}, 8'h00);
    chk("R11 pointer after reset", ptr_val, 8'h00);
    rd(7'h0C, d); chk("R11 byte after reset", d, 8'h00);
    chk("R2 ready high", {7'd0, wr_ready}, 8'h01);
  endtask

  task automatic t_direct();
    logic [7:0] d;
    wr(7'h0C, 8'hA5);
    wr(7'h7F, 8'h5A);
    rd(7'h0C, d); chk("R5 bank0 low gpr", d, 8'hA5);
    rd(7'h7F, d); chk("R5 bank0 top gpr", d, 8'h5A);
    @(negedge clk);
    wr_addr = 7'h0C; wr_data = 8'hFF; wr_valid = 1'b0;
    @(negedge clk);
    rd(7'h0C, d); chk("R2 no write without valid", d, 8'hA5);
    @(negedge clk);
    wr_addr = 7'h10; wr_data = 8'h33; wr_valid = 1'b1; rd_addr = 7'h10;
    #1 chk("R2 read before edge", rd_data, 8'h00);
    @(negedge clk);
    wr_valid = 1'b0;
    #1 chk("R2 read after edge", rd_data, 8'h33);
  endtask

  task automatic t_bank();
    logic [7:0] d;
    @(negedge clk);
    wr_addr = 7'h03; wr_data = 8'h20; wr_valid = 1'b1; rd_addr = 7'h30;
    wr_valid = 1'b1;
    #1 chk("R1 old bank before edge", {6'd0, bank_sel}, 8'h00);
    @(negedge clk);
    wr_valid = 1'b0;
    #1 chk("R1 bank 1 after status write", {6'd0, bank_sel}, 8'h01);
    rd(7'h0C, d); chk("R6 bank1 alias read", d, 8'hA5);
    wr(7'h2F, 8'h77);
    wr(7'h30, 8'h44);
    rd(7'h30, d); chk("R7 bank1 own storage", d, 8'h44);
    wr(7'h50, 8'h99);
    rd(7'h50, d); chk("R7 bank1 hole", d, 8'h00);
    set_status(8'h00);
    rd(7'h2F, d); chk("R6 alias write seen in bank0", d, 8'h77);
    rd(7'h30, d); chk("R7 bank0 separate from bank1", d, 8'h00);
  endtask

  task automatic t_mirror();
    logic [7:0] d;
    set_status(8'h20);
    wr(7'h0A, 8'h12);
    wr(7'h05, 8'h66);
    set_status(8'h00);
    rd(7'h0A, d); chk("R3 shared reg from bank0", d, 8'h12);
    wr(7'h05, 8'h11);
    rd(7'h05, d); chk("R4 bank0 sfr", d, 8'h11);
    rd(7'h03, d); chk("R3 status readable", d, 8'h00);
    set_status(8'h20);
    rd(7'h05, d); chk("R4 bank1 sfr separate", d, 8'h66);
  endtask

  task automatic t_upper();
    logic [7:0] d;
    set_status(8'h40);
    chk("R1 bank 2 selected", {6'd0, bank_sel}, 8'h02);
    wr(7'h20, 8'hEE);
    rd(7'h20, d); chk("R8 bank2 gpr hole", d, 8'h00);
    wr(7'h05, 8'h3A);
    rd(7'h05, d); chk("R4 bank2 sfr hole", d, 8'h00);
    rd(7'h0A, d); chk("R3 shared reg from bank2", d, 8'h12);
    wr(7'h04, 8'h3C);
    chk("R12 pointer written from bank2", ptr_val, 8'h3C);
    set_status(8'h60);
    rd(7'h7F, d); chk("R8 bank3 gpr hole", d, 8'h00);
    set_status(8'h00);
    rd(7'h20, d); chk("R8 bank0 untouched by bank2 write", d, 8'h00);
  endtask

  task automatic t_indirect();
    logic [7:0] d;
    wr(7'h04, 8'h0C);
    rd(7'h00, d); chk("R9 indirect read", d, 8'hA5);
    wr(7'h00, 8'h5C);
    rd(7'h0C, d); chk("R9 indirect write lands", d, 8'h5C);
    wr(7'h04, 8'hB0);
    rd(7'h00, d); chk("R9 indirect into bank1 storage", d, 8'h44);
    set_status(8'h80);
    wr(7'h04, 8'h25);
    rd(7'h00, d); chk("R9 indirect bank bit reaches bank2 hole", d, 8'h00);
    set_status(8'h00);
    wr(7'h04, 8'h80);
    rd(7'h00, d); chk("R10 self-indirect reads zero", d, 8'h00);
    wr(7'h00, 8'hAB);
    chk("R10 self-indirect write leaves pointer", ptr_val, 8'h80);
    chk("R10 self-indirect write leaves bank", {6'd0, bank_sel}, 8'h00);
    rd(7'h7F, d); chk("R10 memory unchanged", d, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_bank();
    t_mirror();
    t_upper();
    t_indirect();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule